// File: doc/BRIEF.md
# Bus Master Address Tenure Controller

This block acts as the address-phase master on a split-transaction processor bus. A cache or core hands it one transaction at a time: an address, a burst flag and a direction. The block raises a bus request and waits for the arbiter. When a qualified grant arrives, it either takes the address bus or declines it. It declines when the core cancels the pending transaction before it starts.

While it holds the address tenure, the block drives a busy indication and the transaction address, and sets the output enables for both. Bursts are aligned according to direction. A read burst presents the double word that holds the missing critical word. A write burst presents the start of the 32-byte line. When the address acknowledge arrives, the block signals completion to the core and lets go of the bus. It keeps the busy line driven in its negated state for one cycle, then releases it to high impedance. The busy line is only ever driven by this block and is never sampled back.

Top module: `addr_tenure_ctrl`

## Requirements
- R1: After reset, `bus_req_o`, `busy_o`, `busy_oe_o`, `addr_oe_o` and `done_o` are 0, `req_ready_o` is 1 and `addr_o` is 0.
- R2: A request on `req_valid_i` is taken only while `req_ready_o` is 1 (idle). `bus_req_o` is 1 from the next cycle until the grant is accepted or the transaction is aborted. A request made while the controller is not idle is ignored, and no bus request follows from it.
- R3: When `grant_q_i` is 1 during a cycle with `bus_req_o` at 1 and `abort_i` at 0, then on the next cycle `busy_o`, `busy_oe_o` and `addr_oe_o` are 1 and `bus_req_o` is 0.
- R4: When `abort_i` is 1 during a cycle with `bus_req_o` at 1, the grant is declined whether or not `grant_q_i` is present. On the next cycle `busy_o` and `busy_oe_o` stay 0, `bus_req_o` is 0 and `req_ready_o` is 1, and no `done_o` pulse is produced.
- R5: `grant_q_i` has no effect while no request is pending. `busy_o` stays 0.
- R6: `busy_o` goes to 0 on the cycle after `aack_i` is seen while it is 1. `busy_oe_o` stays 1 for that cycle and is 0 on the cycle after.
- R7: `addr_oe_o` equals `busy_o` on every cycle. `addr_o` reads 0 whenever `addr_oe_o` is 0.
- R8: For a burst write (`req_burst_i`=1, `req_write_i`=1), `addr_o` is the request address with bits [4:0] cleared.
- R9: For a burst read (`req_burst_i`=1, `req_write_i`=0), `addr_o` is the request address with bits [2:0] cleared.
- R10: For a single-beat transfer (`req_burst_i`=0), `addr_o` is the request address unchanged.
- R11: `done_o` is 1 for exactly the cycle in which `aack_i` is 1 while `busy_o` is 1. At any other time, `aack_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core presents a transaction |
| req_addr_i | input | 32 | Transaction byte address |
| req_burst_i | input | 1 | 1: line burst, 0: single beat |
| req_write_i | input | 1 | 1: write, 0: read |
| abort_i | input | 1 | Core cancels the pending transaction |
| req_ready_o | output | 1 | Controller idle, will take a request |
| done_o | output | 1 | Address tenure completed (one cycle) |
| bus_req_o | output | 1 | Bus request to arbiter |
| grant_q_i | input | 1 | Qualified bus grant |
| aack_i | input | 1 | Address acknowledge |
| busy_o | output | 1 | Address bus busy value |
| busy_oe_o | output | 1 | Output enable for busy line |
| addr_o | output | 32 | Driven address value |
| addr_oe_o | output | 1 | Output enable for address bus |

## Verification
The hardest case to reach is a declined grant: the abort has to land in the same cycle as the qualified grant, while the request is still pending. The bench raises `abort_i` and `grant_q_i` together on the cycle after the request is taken. It then checks that busy stays low and the controller is idle again, and repeats this with an abort that arrives without a grant. A second hard case is a core request that arrives during an owned tenure. The bench sends one mid-tenure and then confirms that no bus request follows the release.

// File: rtl/addr_tenure_pkg.sv
package addr_tenure_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_OWN  = 2'd2,
    ST_REL  = 2'd3
  } atc_state_e;
endpackage

// File: rtl/atc_fsm.sv
module atc_fsm
  import addr_tenure_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic abort_i,
  input  logic grant_q_i,
  input  logic aack_i,
  output logic capture_o,
  output logic take_o,
  output logic ack_o,
  output logic rel_o,
  output logic ready_o,
  output logic bus_req_o
);
  atc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) state_d = ST_REQ;
      ST_REQ: begin
        // abort wins over a coincident grant
        if (abort_i)        state_d = ST_IDLE;
        else if (grant_q_i) state_d = ST_OWN;
      end
      ST_OWN:  if (aack_i) state_d = ST_REL;
      ST_REL:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign ready_o   = (state_q == ST_IDLE);
  assign bus_req_o = (state_q == ST_REQ);
  assign capture_o = ready_o && req_valid_i;
  assign take_o    = bus_req_o && grant_q_i && !abort_i;
  assign ack_o     = (state_q == ST_OWN) && aack_i;
  assign rel_o     = (state_q == ST_REL);
endmodule

// File: rtl/atc_req_hold.sv
module atc_req_hold #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              burst_i,
  input  logic              write_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              burst_o,
  output logic              write_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      burst_o <= 1'b0;
      write_o <= 1'b0;
    end else if (capture_i) begin
      addr_o  <= addr_i;
      burst_o <= burst_i;
      write_o <= write_i;
    end
  end
endmodule

// File: rtl/atc_addr_gen.sv
module atc_addr_gen #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned BEAT_BYTES = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              burst_i,
  input  logic              write_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned LINE_LSB = $clog2(LINE_BYTES);
  localparam int unsigned BEAT_LSB = $clog2(BEAT_BYTES);
  localparam logic [ADDR_W-1:0] LINE_MASK = {{(ADDR_W-LINE_LSB){1'b1}}, {LINE_LSB{1'b0}}};
  localparam logic [ADDR_W-1:0] BEAT_MASK = {{(ADDR_W-BEAT_LSB){1'b1}}, {BEAT_LSB{1'b0}}};

  always_comb begin
    if (!burst_i)     addr_o = addr_i;
    else if (write_i) addr_o = addr_i & LINE_MASK;  // line start
    else              addr_o = addr_i & BEAT_MASK;  // critical double word
  end
endmodule

// File: rtl/atc_drive_regs.sv
module atc_drive_regs #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              ack_i,
  input  logic              rel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe_o,
  output logic              busy_o,
  output logic              busy_oe_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      addr_oe_o <= 1'b0;
      busy_o    <= 1'b0;
      busy_oe_o <= 1'b0;
    end else begin
      if (take_i) addr_q <= addr_i;
      if (take_i) begin
        addr_oe_o <= 1'b1;
        busy_o    <= 1'b1;
        busy_oe_o <= 1'b1;
      end else begin
        if (ack_i) begin
          addr_oe_o <= 1'b0;
          busy_o    <= 1'b0;
        end
        // busy line driven negated for one cycle before release
        if (rel_i) busy_oe_o <= 1'b0;
      end
    end
  end

  assign addr_o = addr_oe_o ? addr_q : '0;
endmodule

// File: rtl/addr_tenure_ctrl.sv
module addr_tenure_ctrl #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned BEAT_BYTES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_burst_i,
  input  logic              req_write_i,
  input  logic              abort_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic              bus_req_o,
  input  logic              grant_q_i,
  input  logic              aack_i,
  output logic              busy_o,
  output logic              busy_oe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe_o
);
  logic              capture, take, ack, rel;
  logic [ADDR_W-1:0] held_addr, gen_addr;
  logic              held_burst, held_write;

  atc_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .abort_i     (abort_i),
    .grant_q_i   (grant_q_i),
    .aack_i      (aack_i),
    .capture_o   (capture),
    .take_o      (take),
    .ack_o       (ack),
    .rel_o       (rel),
    .ready_o     (req_ready_o),
    .bus_req_o   (bus_req_o)
  );

  atc_req_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .addr_i    (req_addr_i),
    .burst_i   (req_burst_i),
    .write_i   (req_write_i),
    .addr_o    (held_addr),
    .burst_o   (held_burst),
    .write_o   (held_write)
  );

  atc_addr_gen #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .BEAT_BYTES (BEAT_BYTES)
  ) u_gen (
    .addr_i  (held_addr),
    .burst_i (held_burst),
    .write_i (held_write),
    .addr_o  (gen_addr)
  );

  atc_drive_regs #(.ADDR_W(ADDR_W)) u_drive (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .ack_i     (ack),
    .rel_i     (rel),
    .addr_i    (gen_addr),
    .addr_o    (addr_o),
    .addr_oe_o (addr_oe_o),
    .busy_o    (busy_o),
    .busy_oe_o (busy_oe_o)
  );

  assign done_o = ack;
endmodule

// File: rtl/atc_chk.sv
module atc_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              abort_i,
  input logic              req_ready_o,
  input logic              done_o,
  input logic              bus_req_o,
  input logic              grant_q_i,
  input logic              aack_i,
  input logic              busy_o,
  input logic              busy_oe_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              addr_oe_o
);
  // R2
  req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !req_ready_o && !busy_o);
  // R3
  grant_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && grant_q_i && !abort_i) |=> busy_o && busy_oe_o && !bus_req_o);
  // R4
  abort_decline_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && abort_i) |=> !busy_o && !busy_oe_o && req_ready_o);
  // R5
  idle_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_req_o && !busy_o) |=> !busy_o);
  // R6
  busy_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && aack_i) |=> !busy_o && busy_oe_o);
  // R6
  busy_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |=> !busy_oe_o);
  // R7
  addr_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_oe_o == busy_o);
  // R7
  addr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_oe_o |-> addr_o == '0);
  // R7
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(addr_o));
  // R11
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o && aack_i);
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind addr_tenure_ctrl atc_chk #(.ADDR_W(ADDR_W)) u_atc_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .abort_i     (abort_i),
  .req_ready_o (req_ready_o),
  .done_o      (done_o),
  .bus_req_o   (bus_req_o),
  .grant_q_i   (grant_q_i),
  .aack_i      (aack_i),
  .busy_o      (busy_o),
  .busy_oe_o   (busy_oe_o),
  .addr_o      (addr_o),
  .addr_oe_o   (addr_oe_o)
);

// File: tb/tb_addr_tenure_ctrl.sv
`timescale 1ns/1ps
module tb_addr_tenure_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        req_burst_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic        abort_i = 1'b0;
  logic        grant_q_i = 1'b0;
  logic        aack_i = 1'b0;
  logic        req_ready_o, done_o, bus_req_o, busy_o, busy_oe_o, addr_oe_o;
  logic [31:0] addr_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  addr_tenure_ctrl dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .req_burst_i (req_burst_i),
    .req_write_i (req_write_i),
    .abort_i     (abort_i),
    .req_ready_o (req_ready_o),
    .done_o      (done_o),
    .bus_req_o   (bus_req_o),
    .grant_q_i   (grant_q_i),
    .aack_i      (aack_i),
    .busy_o      (busy_o),
    .busy_oe_o   (busy_oe_o),
    .addr_o      (addr_o),
    .addr_oe_o   (addr_oe_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic issue(input logic [31:0] a, input logic b, input logic w);
    req_valid_i = 1'b1; req_addr_i = a; req_burst_i = b; req_write_i = w;
    tick();
    req_valid_i = 1'b0; req_addr_i = 32'hFFFF_FFFF;
  endtask

  task automatic test_reset();
    chk("R1", "bus_req", bus_req_o, 0);
    chk("R1", "busy", busy_o, 0);
    chk("R1", "busy_oe", busy_oe_o, 0);
    chk("R1", "addr_oe", addr_oe_o, 0);
    chk("R1", "done", done_o, 0);
    chk("R1", "ready", req_ready_o, 1);
    chk("R1", "addr", addr_o, 0);
  endtask

  task automatic test_tenure(input string tag, input logic [31:0] a, input logic b,
                             input logic w, input logic [31:0] exp_addr);
    issue(a, b, w);
    chk("R2", "bus_req after request", bus_req_o, 1);
    chk("R2", "ready while pending", req_ready_o, 0);
    tick();
    chk("R2", "bus_req held", bus_req_o, 1);
    chk("R3", "busy before grant", busy_o, 0);
    grant_q_i = 1'b1;
    tick();
    grant_q_i = 1'b0;
    chk("R3", "busy after grant", busy_o, 1);
    chk("R3", "busy_oe after grant", busy_oe_o, 1);
    chk("R3", "bus_req dropped", bus_req_o, 0);
    chk("R7", "addr_oe with busy", addr_oe_o, 1);
    chk(tag, "driven address", addr_o, exp_addr);
    tick();
    chk(tag, "address held", addr_o, exp_addr);
    chk("R11", "no done before aack", done_o, 0);
    aack_i = 1'b1;
    #1;
    chk("R11", "done on aack", done_o, 1);
    tick();
    aack_i = 1'b0;
    chk("R6", "busy negated", busy_o, 0);
    chk("R6", "busy_oe held one cycle", busy_oe_o, 1);
    chk("R7", "addr_oe off", addr_oe_o, 0);
    chk("R7", "addr quiet", addr_o, 0);
    chk("R11", "done one cycle", done_o, 0);
    tick();
    chk("R6", "busy_oe released", busy_oe_o, 0);
    chk("R2", "ready again", req_ready_o, 1);
  endtask

  task automatic test_abort(input logic with_grant);
    issue(32'h0000_1008, 1'b1, 1'b0);
    chk("R4", "bus_req pending", bus_req_o, 1);
    abort_i = 1'b1; grant_q_i = with_grant;
    #1;
    chk("R4", "no done on abort", done_o, 0);
    tick();
    abort_i = 1'b0; grant_q_i = 1'b0;
    chk("R4", "busy stays low", busy_o, 0);
    chk("R4", "busy_oe stays low", busy_oe_o, 0);
    chk("R4", "bus_req dropped", bus_req_o, 0);
    chk("R4", "ready after abort", req_ready_o, 1);
    tick();
    chk("R4", "still not owner", busy_o, 0);
  endtask

  task automatic test_idle_grant();
    grant_q_i = 1'b1; aack_i = 1'b1;
    #1;
    chk("R11", "aack idle no done", done_o, 0);
    tick();
    chk("R5", "idle grant no busy", busy_o, 0);
    chk("R5", "idle grant no addr_oe", addr_oe_o, 0);
    chk("R5", "idle grant no bus_req", bus_req_o, 0);
    grant_q_i = 1'b0; aack_i = 1'b0;
    tick();
  endtask

  task automatic test_req_while_busy();
    issue(32'h0000_0040, 1'b0, 1'b0);
    grant_q_i = 1'b1;
    tick();
    grant_q_i = 1'b0;
    chk("R2", "ready low while owner", req_ready_o, 0);
    req_valid_i = 1'b1; req_addr_i = 32'hAAAA_AAAA;
    tick();
    req_valid_i = 1'b0;
    chk("R10", "address unaffected", addr_o, 32'h0000_0040);
    aack_i = 1'b1;
    tick();
    aack_i = 1'b0;
    tick();
    tick();
    chk("R2", "ignored request no bus_req", bus_req_o, 0);
    chk("R2", "idle after ignored request", req_ready_o, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    test_reset();
    rst_ni = 1'b1;
    tick();
    test_reset();
    test_tenure("R8", 32'h1234_567C, 1'b1, 1'b1, 32'h1234_5660);
    test_tenure("R9", 32'h1234_567C, 1'b1, 1'b0, 32'h1234_5678);
    test_tenure("R10", 32'h1234_567C, 1'b0, 1'b0, 32'h1234_567C);
    test_tenure("R8", 32'hDEAD_BEEF, 1'b1, 1'b1, 32'hDEAD_BEE0);
    test_tenure("R9", 32'hDEAD_BEEF, 1'b1, 1'b0, 32'hDEAD_BEE8);
    test_tenure("R10", 32'hDEAD_BEEF, 1'b0, 1'b1, 32'hDEAD_BEEF);
    test_abort(1'b1);
    test_abort(1'b0);
    test_idle_grant();
    test_req_while_busy();
    test_tenure("R9", 32'h0000_001F, 1'b1, 1'b0, 32'h0000_0018);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule